// File: doc/BRIEF.md
# Soft-Mute Ramp Sequencer

This block drives a digital gain multiplier that takes an audio path into and out of mute along a smooth S-shaped trajectory, so the signal envelope never jumps. A mute is requested either by an active-low external pin or by a bus-controlled bit; the two are ORed. The ramp length is chosen by a two-bit selector whose four settings scale the per-step period by 1, 2, 64 and 256 (with the default divider at a 125 MHz clock these give roughly 0.48 ms, 0.96 ms, 30.7 ms and 122.9 ms).

Once a ramp begins it runs to its end whatever the request does meanwhile. When a ramp ends and the request already points the other way, the opposite ramp starts straight away. A busy flag tells the host that the path is somewhere between the start of muting and the end of un-muting. A separate direct-mute input zeroes the gain at once, bypassing the ramp, and leaves the sequencer untouched so that the sequenced level returns when it is released.

Top module: `softMuteSeq`

## Requirements
- R1: After reset the gain output equals full scale (2^GAIN_W-1, 65535 by default) and busy is 0.
- R2: The mute request is (muteN == 0) OR (busMute == 1); from the idle state a request starts the falling ramp on the next clock edge and busy reads 1 after that edge.
- R3: A ramp has STEPS (32) steps; the step period in clocks is BASE_DIV times 1, 2, 64 or 256 for timeSel = 0, 1, 2, 3. timeSel is captured when a ramp starts; later changes do not alter that ramp.
- R4: The gain at ramp position p (0..STEPS) is floor(FULL * p^2 * (3*STEPS - 2*p) / STEPS^3); on a falling ramp p starts at STEPS and drops by one per step, the first step landing one step period after the ramp starts.
- R5: A ramp that has begun always completes, even if the request is withdrawn or reasserted during it.
- R6: When a ramp ends and the request is of the opposite sense, the opposite ramp starts on the next edge (position counter restarted); otherwise the level is held.
- R7: busy stays 1 from the start of muting until the edge after the rising ramp reaches full scale, including through a reversal at either end.
- R8: The fully muted gain is exactly 0.
- R9: directMute = 1 forces gain to 0 combinationally without changing the ramp position; on release the gain shows the current sequenced level.
- R10: On a rising ramp p rises by one per step from 0 to STEPS, the first step one step period after the ramp starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| muteN | input | 1 | Active-low mute request pin |
| busMute | input | 1 | Bus-controlled mute request bit |
| timeSel | input | 2 | Ramp duration select |
| directMute | input | 1 | Immediate mute, bypassing the ramp |
| gain | output | GAIN_W | Gain multiplier, 0 to full scale |
| busy | output | 1 | High while muting, muted or un-muting |

## Verification
The bench samples the gain one cycle on each side of the first step, so a design that stepped immediately or one cycle late would show the wrong level. Withdrawing the request mid-fall and reasserting it mid-rise targets an interruptible ramp, which would reverse early instead of reaching zero or full scale, and a missing end-of-ramp reversal, which would leave the gain stuck. Changing timeSel mid-ramp catches a design that reads the selector live and shortens or stretches a running ramp. Applying direct mute during a ramp catches a design that freezes or resets the position rather than merely masking the output.

// File: rtl/softMuteSeq_pkg.sv
package softMuteSeq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FALL,
    PH_HOLD,
    PH_RISE
  } phase_t;

  typedef struct packed {
    logic stepDown;
    logic stepUp;
  } rampCmd_t;

  localparam int SHIFT_SEL0 = 0;
  localparam int SHIFT_SEL1 = 1;
  localparam int SHIFT_SEL2 = 6;
  localparam int SHIFT_SEL3 = 8;

  function automatic longint sCurve(int k, int n, int w);
    longint fullScale;
    longint kk;
    longint nn;
    fullScale = (longint'(1) << w) - 1;
    kk = longint'(k);
    nn = longint'(n);
    return (fullScale * kk * kk * (3 * nn - 2 * kk)) / (nn * nn * nn);
  endfunction

endpackage

// File: rtl/softMuteSeqCtrl.sv
module softMuteSeqCtrl
  import softMuteSeq_pkg::*;
#(
  parameter int BASE_DIV = 1875
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       req,
  input  logic [1:0] timeSel,
  input  logic       atMin,
  input  logic       atMax,
  output rampCmd_t   cmd,
  output logic       busy
);

  localparam int MAX_PER = BASE_DIV << SHIFT_SEL3;
  localparam int CNT_W   = $clog2(MAX_PER + 1);
  localparam logic [CNT_W-1:0] LIM0 = CNT_W'((BASE_DIV << SHIFT_SEL0) - 1);
  localparam logic [CNT_W-1:0] LIM1 = CNT_W'((BASE_DIV << SHIFT_SEL1) - 1);
  localparam logic [CNT_W-1:0] LIM2 = CNT_W'((BASE_DIV << SHIFT_SEL2) - 1);
  localparam logic [CNT_W-1:0] LIM3 = CNT_W'((BASE_DIV << SHIFT_SEL3) - 1);

  phase_t           phase;
  logic [1:0]       selQ;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] limit;
  logic             tick;

  always_comb begin
    case (selQ)
      2'd0:    limit = LIM0;
      2'd1:    limit = LIM1;
      2'd2:    limit = LIM2;
      default: limit = LIM3;
    endcase
  end

  assign tick = (divCnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      selQ   <= 2'd0;
      divCnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (req) begin
            phase  <= PH_FALL;
            selQ   <= timeSel;
            divCnt <= '0;
          end
        end
        PH_FALL: begin
          if (atMin) begin
            phase  <= req ? PH_HOLD : PH_RISE;
            selQ   <= timeSel;
            divCnt <= '0;
          end else if (tick) begin
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        PH_HOLD: begin
          if (!req) begin
            phase  <= PH_RISE;
            selQ   <= timeSel;
            divCnt <= '0;
          end
        end
        default: begin
          if (atMax) begin
            phase  <= req ? PH_FALL : PH_IDLE;
            selQ   <= timeSel;
            divCnt <= '0;
          end else if (tick) begin
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    cmd.stepDown = (phase == PH_FALL) && !atMin && tick;
    cmd.stepUp   = (phase == PH_RISE) && !atMax && tick;
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/softMuteSeqPath.sv
module softMuteSeqPath
  import softMuteSeq_pkg::*;
#(
  parameter int STEPS  = 32,
  parameter int GAIN_W = 16,
  parameter int POS_W  = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rampCmd_t          cmd,
  input  logic              directMute,
  output logic [POS_W-1:0]  pos,
  output logic              atMin,
  output logic              atMax,
  output logic [GAIN_W-1:0] gain
);

  localparam logic [POS_W-1:0] POS_TOP = POS_W'(STEPS);

  logic [GAIN_W-1:0] curve [STEPS+1];

  for (genvar k = 0; k <= STEPS; k++) begin : g_curve
    assign curve[k] = GAIN_W'(sCurve(k, STEPS, GAIN_W));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos <= POS_TOP;
    end else if (cmd.stepDown) begin
      pos <= pos - 1'b1;
    end else if (cmd.stepUp) begin
      pos <= pos + 1'b1;
    end
  end

  assign atMin = (pos == '0);
  assign atMax = (pos == POS_TOP);
  assign gain  = directMute ? '0 : curve[pos];

endmodule

// File: rtl/softMuteSeq.sv
module softMuteSeq
  import softMuteSeq_pkg::*;
#(
  parameter int STEPS    = 32,
  parameter int GAIN_W   = 16,
  parameter int BASE_DIV = 1875
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              muteN,
  input  logic              busMute,
  input  logic [1:0]        timeSel,
  input  logic              directMute,
  output logic [GAIN_W-1:0] gain,
  output logic              busy
);

  localparam int POS_W = $clog2(STEPS + 1);

  rampCmd_t         cmd;
  logic [POS_W-1:0] pos;
  logic             atMin;
  logic             atMax;
  logic             req;

  assign req = !muteN || busMute;

  softMuteSeqCtrl #(
    .BASE_DIV(BASE_DIV)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .req    (req),
    .timeSel(timeSel),
    .atMin  (atMin),
    .atMax  (atMax),
    .cmd    (cmd),
    .busy   (busy)
  );

  softMuteSeqPath #(
    .STEPS (STEPS),
    .GAIN_W(GAIN_W),
    .POS_W (POS_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .directMute(directMute),
    .pos       (pos),
    .atMin     (atMin),
    .atMax     (atMax),
    .gain      (gain)
  );

endmodule

// File: rtl/softMuteSeqChk.sv
module softMuteSeqChk
  import softMuteSeq_pkg::*;
#(
  parameter int GAIN_W = 16,
  parameter int POS_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              muteN,
  input logic              busMute,
  input logic              directMute,
  input logic [GAIN_W-1:0] gain,
  input logic              busy,
  input rampCmd_t          cmd,
  input logic [POS_W-1:0]  pos
);

  localparam logic [GAIN_W-1:0] FULL = '1;

  logic reqSeen;
  assign reqSeen = !muteN || busMute;

  // R2: an idle block answers a request with busy on the next edge
  a_r2_request_starts: assert property (@(posedge clk) disable iff (!rstN)
    (reqSeen && !busy) |=> busy);

  // R4: a falling step lowers the position by exactly one
  a_r4_fall_by_one: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stepDown |=> (pos == POS_W'($past(pos) - 1'b1)));

  // R10: a rising step raises the position by exactly one
  a_r10_rise_by_one: assert property (@(posedge clk) disable iff (!rstN)
    cmd.stepUp |=> (pos == POS_W'($past(pos) + 1'b1)));

  // R7: busy only drops once the path is back at full scale
  a_r7_busy_ends_full: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (gain == FULL || directMute));

  // R8: a sequenced zero gain only exists while busy
  a_r8_zero_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!directMute && gain == '0) |-> busy);

  // R5: ramp stepping only happens inside the busy span
  a_r5_steps_inside_busy: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepDown || cmd.stepUp) |-> busy);

endmodule

bind softMuteSeq softMuteSeqChk #(
  .GAIN_W(GAIN_W),
  .POS_W (POS_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .muteN     (muteN),
  .busMute   (busMute),
  .directMute(directMute),
  .gain      (gain),
  .busy      (busy),
  .cmd       (cmd),
  .pos       (pos)
);

// File: tb/sim_softMuteSeq.sv
`timescale 1ns/1ps
module sim_softMuteSeq;

  localparam int STEPS    = 32;
  localparam int GAIN_W   = 16;
  localparam int BASE_DIV = 2;
  localparam longint FULL = (longint'(1) << GAIN_W) - 1;

  // sel, step period in clocks, request via pin (1) or bus bit (0)
  localparam int VEC [4][3] = '{
    '{0,   2, 1},
    '{1,   4, 0},
    '{2, 128, 1},
    '{3, 512, 0}
  };

  logic              clk = 0;
  logic              rstN = 0;
  logic              muteN = 1;
  logic              busMute = 0;
  logic [1:0]        timeSel = 0;
  logic              directMute = 0;
  logic [GAIN_W-1:0] gain;
  logic              busy;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  softMuteSeq #(
    .STEPS   (STEPS),
    .GAIN_W  (GAIN_W),
    .BASE_DIV(BASE_DIV)
  ) u0 (
    .clk       (clk),
    .rstN      (rstN),
    .muteN     (muteN),
    .busMute   (busMute),
    .timeSel   (timeSel),
    .directMute(directMute),
    .gain      (gain),
    .busy      (busy)
  );

  function automatic longint expGain(int p);
    longint lp = longint'(p);
    return (FULL * lp * lp * (3 * STEPS - 2 * lp)) / (longint'(STEPS) * STEPS * STEPS);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic waitNeg(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setReq(bit on, bit viaPin);
    if (viaPin) muteN = !on;
    else        busMute = on;
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    waitNeg(3);
    rstN = 1;
    waitNeg(2);
    chk("R1 reset gain", gain, FULL);
    chk("R1 reset busy", busy, 0);

    // table walk: full mute and un-mute per duration setting
    for (int v = 0; v < 4; v++) begin
      int sel = VEC[v][0];
      int per = VEC[v][1];
      bit pin = VEC[v][2][0];
      timeSel = 2'(sel);
      setReq(1, pin);
      waitNeg(per);
      chk("R4 no step before one period", gain, FULL);
      waitNeg(1);
      chk("R4 first fall step", gain, expGain(STEPS - 1));
      chk("R2 busy after request", busy, 1);
      timeSel = ~2'(sel);
      waitNeg(15 * per);
      chk("R3 midpoint timing kept", gain, expGain(STEPS - 16));
      waitNeg(16 * per - 1);
      chk("R3 last nonzero level", gain, expGain(1));
      waitNeg(1);
      chk("R8 muted gain zero", gain, 0);
      waitNeg(3);
      chk("R6 hold while requested", gain, 0);
      chk("R7 busy while muted", busy, 1);
      timeSel = 2'(sel);
      setReq(0, pin);
      waitNeg(per);
      chk("R10 no rise before one period", gain, 0);
      waitNeg(1);
      chk("R10 first rise step", gain, expGain(1));
      waitNeg(31 * per);
      chk("R10 rise reaches full", gain, FULL);
      chk("R7 busy at rise end", busy, 1);
      waitNeg(1);
      chk("R7 busy clears", busy, 0);
      waitNeg(2);
    end

    // R9 direct mute in idle
    timeSel = 0;
    directMute = 1;
    #1;
    chk("R9 direct mute zero", gain, 0);
    chk("R9 busy untouched", busy, 0);
    waitNeg(1);
    directMute = 0;
    #1;
    chk("R9 release restores", gain, FULL);
    waitNeg(1);

    // R5 and R6: withdraw request mid-fall
    setReq(1, 1);
    waitNeg(10);
    setReq(0, 1);
    waitNeg(64 - 10 + 1);
    chk("R5 fall completes", gain, 0);
    waitNeg(2);
    chk("R6 reversal timing", gain, 0);
    waitNeg(1);
    chk("R6 reversal first step", gain, expGain(1));
    waitNeg(62);
    chk("R6 rise reaches full", gain, FULL);
    waitNeg(1);
    chk("R7 idle after reversal", busy, 0);

    // R5 and R6: reassert during rise, reverse at the top
    setReq(1, 0);
    waitNeg(64 + 3);
    setReq(0, 0);
    waitNeg(10);
    setReq(1, 0);
    waitNeg(64 + 1 - 10);
    chk("R5 rise completes", gain, FULL);
    waitNeg(1);
    chk("R7 busy through top reversal", busy, 1);
    waitNeg(2);
    chk("R6 fall restarts", gain, expGain(STEPS - 1));
    setReq(0, 0);
    waitNeg(200);
    chk("R6 back to idle gain", gain, FULL);
    chk("R6 back to idle busy", busy, 0);

    // R9 direct mute mid-ramp keeps the position
    setReq(1, 1);
    waitNeg(21);
    chk("R4 tenth fall step", gain, expGain(STEPS - 10));
    directMute = 1;
    #1;
    chk("R9 direct mute mid ramp", gain, 0);
    waitNeg(2);
    directMute = 0;
    #1;
    chk("R9 ramp kept running", gain, expGain(STEPS - 11));
    setReq(0, 1);
    waitNeg(200);
    chk("R9 recovery to idle", busy, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule